// File: doc/BRIEF.md
# Millisecond Periodic Interrupt Timer

This block is the periodic-alarm part of a real-time clock. A 1 kHz enable pulse, made elsewhere from the system clock, advances a millisecond counter. Software programs the wanted interval in milliseconds into a period register. To run at a frequency F between 1 and 1000 Hz, it writes 1000 / F. When the counter reaches the period, the block raises a one-cycle alarm pulse, the count wraps to zero, and counting continues.

The count enable and the alarm enable come from a status register outside this block and are separate inputs. The counter can therefore run while its alarm is masked. Software reaches the block through a simple register port. The count register sits at byte offset 0x34 and the period register at 0x38. Both are 16 bits wide and are zero-extended on a 32-bit read bus.

Top module: `pit_timer`

## Requirements
- R1: After reset the count and the period both read 0 and the alarm pulse is low.
- R2: While the count enable is low, the count is held at 0 and millisecond ticks have no effect.
- R3: With the count enable high, each cycle in which the tick input is high adds one to the count. A cycle with no tick and no period write leaves the count unchanged.
- R4: A tick that would make the count equal a nonzero period returns the count to 0 instead, so the count never reads as the period value. The alarm pulse is high for exactly the one cycle after that tick edge.
- R5: The alarm pulse is raised only when the alarm enable was high at the wrapping tick. With the alarm enable low, the count still wraps at the period.
- R6: A write to offset 0x38 loads bits 15:0 of the write data into the period and clears the count to 0. When it coincides with a tick, the write wins: the count becomes 0 and no alarm is raised.
- R7: With a period of 0, no alarm pulse is ever raised, and the count keeps advancing on each enabled tick.
- R8: A read at offset 0x34 returns the count and a read at offset 0x38 returns the period, each in bits 15:0 with bits 31:16 zero. Any other offset reads 0.
- R9: The count register is read-only: a write to offset 0x34 leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickMs | input | 1 | One-cycle 1 kHz millisecond enable |
| cntEn | input | 1 | Count enable from the status register |
| almEn | input | 1 | Alarm enable from the status register |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data (combinational from addr) |
| almPulse | output | 1 | One-cycle periodic alarm event |

## Verification
The bench targets the wrap point. A design that compared the count before incrementing would let the count read the period value and fire one tick late. The bench also checks a period of 1, where every tick must fire; an off-by-one design would skip every other tick or never fire. A period write landing on the same cycle as a tick is covered, and a design giving the tick priority would show a count of 1 or a stray alarm. Further checks cover a zero period, which a naive equality test could turn into a wrap at 65536 or an immediate alarm, and a masked alarm enable, which must still let the count wrap while no alarm escapes.

// File: rtl/pit_pkg.sv
package pit_pkg;

  // Strobes from control to datapath, at most one count action per cycle.
  typedef struct packed {
    logic loadPeriod;  // take new period, clear count
    logic clrCount;    // force count to zero
    logic incCount;    // count + 1
    logic wrapCount;   // count reached period, return to zero
  } pitStrobe_t;

endpackage

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int unsigned REG_W = 16,
  parameter int unsigned BUS_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  pitStrobe_t       strobe,
  input  logic [BUS_W-1:0] wrData,
  output logic [REG_W-1:0] countQ,
  output logic [REG_W-1:0] periodQ,
  output logic             match
);

  logic [REG_W-1:0] countInc;

  assign countInc = countQ + {{(REG_W-1){1'b0}}, 1'b1};
  // A zero period never matches, so it can never wrap or fire.
  assign match    = (periodQ != '0) && (countInc == periodQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodQ <= '0;
    end else if (strobe.loadPeriod) begin
      periodQ <= wrData[REG_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobe.loadPeriod || strobe.clrCount || strobe.wrapCount) begin
      countQ <= '0;
    end else if (strobe.incCount) begin
      countQ <= countInc;
    end
  end

endmodule

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter logic [7:0]  PERIOD_OFF = 8'h38
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickMs,
  input  logic              cntEn,
  input  logic              almEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              match,
  output pitStrobe_t        strobe,
  output logic              almPulse
);

  logic periodWr;
  logic tickLive;

  assign periodWr = wrEn && (addr == ADDR_W'(PERIOD_OFF));
  // A period write takes priority over a tick arriving in the same cycle.
  assign tickLive = tickMs && cntEn && !periodWr;

  always_comb begin
    strobe            = '0;
    strobe.loadPeriod = periodWr;
    strobe.clrCount   = !cntEn;
    strobe.incCount   = tickLive && !match;
    strobe.wrapCount  = tickLive && match;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      almPulse <= 1'b0;
    end else begin
      almPulse <= tickLive && match && almEn;
    end
  end

endmodule

// File: rtl/pit_readmux.sv
module pit_readmux #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned REG_W      = 16,
  parameter int unsigned BUS_W      = 32,
  parameter logic [7:0]  COUNT_OFF  = 8'h34,
  parameter logic [7:0]  PERIOD_OFF = 8'h38
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  countQ,
  input  logic [REG_W-1:0]  periodQ,
  output logic [BUS_W-1:0]  rdData
);

  localparam int unsigned PAD_W = BUS_W - REG_W;

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(COUNT_OFF)) begin
      rdData = {{PAD_W{1'b0}}, countQ};
    end else if (addr == ADDR_W'(PERIOD_OFF)) begin
      rdData = {{PAD_W{1'b0}}, periodQ};
    end
  end

endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned BUS_W      = 32,
  parameter int unsigned REG_W      = 16,
  parameter logic [7:0]  COUNT_OFF  = 8'h34,
  parameter logic [7:0]  PERIOD_OFF = 8'h38
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickMs,
  input  logic              cntEn,
  input  logic              almEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wrData,
  output logic [BUS_W-1:0]  rdData,
  output logic              almPulse
);

  pitStrobe_t       strobe;
  logic             match;
  logic [REG_W-1:0] countVal;
  logic [REG_W-1:0] periodVal;

  pit_ctrl #(
    .ADDR_W    (ADDR_W),
    .PERIOD_OFF(PERIOD_OFF)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tickMs  (tickMs),
    .cntEn   (cntEn),
    .almEn   (almEn),
    .wrEn    (wrEn),
    .addr    (addr),
    .match   (match),
    .strobe  (strobe),
    .almPulse(almPulse)
  );

  pit_datapath #(
    .REG_W(REG_W),
    .BUS_W(BUS_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .countQ (countVal),
    .periodQ(periodVal),
    .match  (match)
  );

  pit_readmux #(
    .ADDR_W    (ADDR_W),
    .REG_W     (REG_W),
    .BUS_W     (BUS_W),
    .COUNT_OFF (COUNT_OFF),
    .PERIOD_OFF(PERIOD_OFF)
  ) u_rd (
    .addr   (addr),
    .countQ (countVal),
    .periodQ(periodVal),
    .rdData (rdData)
  );

endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned BUS_W      = 32,
  parameter int unsigned REG_W      = 16,
  parameter logic [7:0]  COUNT_OFF  = 8'h34,
  parameter logic [7:0]  PERIOD_OFF = 8'h38
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickMs,
  input logic              cntEn,
  input logic              almEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [BUS_W-1:0]  wrData,
  input logic [REG_W-1:0]  countVal,
  input logic [REG_W-1:0]  periodVal,
  input logic              almPulse
);

  logic perWr;
  logic cntWr;
  assign perWr = wrEn && (addr == ADDR_W'(PERIOD_OFF));
  assign cntWr = wrEn && (addr == ADDR_W'(COUNT_OFF));

  // R2: disabled counter sits at zero
  a_r2_hold_zero: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn |=> (countVal == '0));

  // R3: no tick, no write -> count does not move
  a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && !tickMs && !perWr) |=> $stable(countVal));

  // R4: count never shows the nonzero period value
  a_r4_below_period: assert property (@(posedge clk) disable iff (!rstN)
    (periodVal != '0) |-> (countVal < periodVal));

  // R5: alarm needs the alarm enable at the wrapping tick
  a_r5_alarm_masked: assert property (@(posedge clk) disable iff (!rstN)
    almPulse |-> ($past(almEn) && $past(tickMs) && $past(cntEn)));

  // R6: period write loads low bits and clears count
  a_r6_period_load: assert property (@(posedge clk) disable iff (!rstN)
    perWr |=> ((countVal == '0) && (periodVal == $past(wrData[REG_W-1:0])) && !almPulse));

  // R7: zero period never raises an alarm
  a_r7_zero_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (periodVal == '0) |=> !almPulse);

  // R9: a write to the count offset leaves the period untouched
  a_r9_count_ro: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> $stable(periodVal));

endmodule

bind pit_timer pit_timer_chk #(
  .ADDR_W    (ADDR_W),
  .BUS_W     (BUS_W),
  .REG_W     (REG_W),
  .COUNT_OFF (COUNT_OFF),
  .PERIOD_OFF(PERIOD_OFF)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tickMs   (tickMs),
  .cntEn    (cntEn),
  .almEn    (almEn),
  .wrEn     (wrEn),
  .addr     (addr),
  .wrData   (wrData),
  .countVal (countVal),
  .periodVal(periodVal),
  .almPulse (almPulse)
);

// File: tb/sim_pit_timer.sv
`timescale 1ns/1ps
module sim_pit_timer;

  localparam logic [7:0] A_CNT = 8'h34;
  localparam logic [7:0] A_PER = 8'h38;

  // op codes for the vector table
  localparam logic [1:0] OP_TICK = 2'd0;
  localparam logic [1:0] OP_WPER = 2'd1;
  localparam logic [1:0] OP_IDLE = 2'd2;

  // {op[2], data[16], expCount[16], expAlarm[1]}
  localparam int NV = 13;
  localparam logic [34:0] VEC [NV] = '{
    {OP_WPER, 16'd3, 16'd0, 1'b0},
    {OP_TICK, 16'd0, 16'd1, 1'b0},
    {OP_TICK, 16'd0, 16'd2, 1'b0},
    {OP_TICK, 16'd0, 16'd0, 1'b1},
    {OP_IDLE, 16'd0, 16'd0, 1'b0},
    {OP_TICK, 16'd0, 16'd1, 1'b0},
    {OP_WPER, 16'd1, 16'd0, 1'b0},
    {OP_TICK, 16'd0, 16'd0, 1'b1},
    {OP_TICK, 16'd0, 16'd0, 1'b1},
    {OP_WPER, 16'd2, 16'd0, 1'b0},
    {OP_TICK, 16'd0, 16'd1, 1'b0},
    {OP_IDLE, 16'd0, 16'd1, 1'b0},
    {OP_TICK, 16'd0, 16'd0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickMs = 1'b0;
  logic        cntEn = 1'b0;
  logic        almEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = A_CNT;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        almPulse;

  int nChk = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;

  pit_timer u0 (
    .clk(clk), .rstN(rstN), .tickMs(tickMs), .cntEn(cntEn), .almEn(almEn),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData), .almPulse(almPulse)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle of stimulus, then settle at the next falling edge reading the count.
  task automatic step(input logic tk, input logic wr, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    tickMs = tk; wrEn = wr; addr = a; wrData = d;
    @(negedge clk);
    tickMs = 1'b0; wrEn = 1'b0; addr = A_CNT; wrData = '0;
    #1;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [31:0] v);
    addr = a; #1; v = rdData; addr = A_CNT; #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1 count", rdData, 32'd0);
    readReg(A_PER, v); check("R1 period", v, 32'd0);
    check("R1 alarm", {31'd0, almPulse}, 32'd0);

    // R2 ticks ignored with count disabled
    step(1'b1, 1'b0, A_CNT, 0);
    step(1'b1, 1'b0, A_CNT, 0);
    check("R2 held", rdData, 32'd0);

    // Table walk, both enables on (R3, R4, R6)
    cntEn = 1'b1; almEn = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [15:0] dat;
      logic [15:0] ec;
      logic        ea;
      {op, dat, ec, ea} = VEC[i];
      step(op == OP_TICK, op == OP_WPER, (op == OP_WPER) ? A_PER : A_CNT, {16'd0, dat});
      check($sformatf("R4 vec%0d count", i), rdData, {16'd0, ec});
      check($sformatf("R4 vec%0d alarm", i), {31'd0, almPulse}, {31'd0, ea});
    end
    // alarm lasts one cycle
    @(negedge clk); #1;
    check("R4 pulse width", {31'd0, almPulse}, 32'd0);

    // R3 no tick leaves count alone
    step(1'b1, 1'b0, A_CNT, 0);
    step(1'b0, 1'b0, A_CNT, 0);
    step(1'b0, 1'b0, A_CNT, 0);
    check("R3 idle", rdData, 32'd1);

    // R2 dropping count enable clears the count
    cntEn = 1'b0;
    step(1'b0, 1'b0, A_CNT, 0);
    check("R2 clear", rdData, 32'd0);
    cntEn = 1'b1;

    // R5 masked alarm, count still wraps (period 2)
    almEn = 1'b0;
    step(1'b1, 1'b0, A_CNT, 0);
    step(1'b1, 1'b0, A_CNT, 0);
    check("R5 alarm masked", {31'd0, almPulse}, 32'd0);
    check("R5 count wrapped", rdData, 32'd0);
    almEn = 1'b1;

    // R6 write with upper bits set, coincident with a wrapping tick
    step(1'b1, 1'b0, A_CNT, 0);
    check("R6 pre count", rdData, 32'd1);
    step(1'b1, 1'b1, A_PER, 32'hABCD_0005);
    check("R6 write wins count", rdData, 32'd0);
    check("R6 write wins alarm", {31'd0, almPulse}, 32'd0);
    readReg(A_PER, v); check("R8 period upper zero", v, 32'h0000_0005);

    // R9 write to count offset ignored
    step(1'b1, 1'b0, A_CNT, 0);
    step(1'b1, 1'b0, A_CNT, 0);
    step(1'b0, 1'b1, A_CNT, 32'h0000_0000);
    check("R9 count kept", rdData, 32'd2);
    readReg(A_PER, v); check("R9 period kept", v, 32'd5);

    // R8 unmapped offset
    readReg(8'h3C, v); check("R8 unmapped", v, 32'd0);

    // R7 zero period: count runs, no alarm
    step(1'b0, 1'b1, A_PER, 32'd0);
    for (int k = 0; k < 6; k++) begin
      step(1'b1, 1'b0, A_CNT, 0);
      check("R7 no alarm", {31'd0, almPulse}, 32'd0);
    end
    check("R7 count runs", rdData, 32'd6);

    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule